// File: doc/BRIEF.md
# Multi-Rate Clock Divider with Mode Select and Stop-Low Gating

The block turns one fast model clock into seven families of synchronous clock outputs: a host (CPU) group, a memory (SDRAM) group, a fixed 66 MHz group, a PCI group, an interrupt-controller (IOAPIC) group, a 48 MHz USB group and a single reference clock. Every output is a counter-derived square wave, re-timed by its own flop, so all groups switch on the same fast-clock edge. In normal modes the fast clock stands for 200 MHz, giving 100 MHz at a period of 2 cycles, 66.6 MHz at 3 cycles and 33.3 MHz at 6 cycles. The USB and reference periods are parameters (`USB_PER`, `REF_PER`), because their true rates are not integer fractions of the model clock.

A two-bit select picks one of four modes. Mode 00 releases the host, memory and PCI output enables, which models tri-stating those pins. Mode 01 is a test mode, in which every group runs at a fixed fraction of a test clock. Mode 10 is the 66 MHz host mode and mode 11 the 100 MHz host mode. A strap input is captured once as reset is released and selects whether the IOAPIC group runs at the PCI rate or at half of it. After capture, the reference output enable asserts, because the shared pin now carries the reference clock.

An active-low power-down input and per-output enable bits from a register neighbour stop outputs. An output only stops or restarts while its level is low, so no shortened pulse ever reaches a pin. While power-down is held, a hold signal freezes the serial register block. Whenever the mode changes, all dividers restart together, which keeps the rising edges of the slower groups aligned with those of the faster ones.

Top module: `clkgen_top`

## Requirements
- R1: With select 10, the host group has a period of 3 fast cycles and the memory group a period of 2. The PCI group has a period of 6. The enables `cpu_oe`, `sdram_oe` and `pci_oe` read 1. Every output is high for floor(period/2) cycles of each period.
- R2: With select 11, the host and memory groups both have a period of 2 cycles and the PCI group a period of 6. The three group enables read 1.
- R3: With select 00, `cpu_oe`, `sdram_oe` and `pci_oe` read 0. The levels behind them keep running at the select-11 periods.
- R4: With select 01, the test clock is taken as 2 fast cycles. The host, memory and USB groups have a period of 4. The 66 MHz group has a period of 6, the PCI and IOAPIC groups a period of 12, and the reference clock a period of 2.
- R5: Outside select 01, the 66 MHz group keeps a period of 3, the USB group a period of USB_PER and the reference clock a period of REF_PER, whatever the select value.
- R6: The strap is captured in the first cycle after reset release. Strap 1 gives the IOAPIC group the PCI period, and strap 0 gives it twice the PCI period (normal modes only). Later changes of the strap have no effect. `ref_oe` is 0 in reset and 1 after capture.
- R7: Every IOAPIC rising edge falls in the same cycle as a PCI rising edge.
- R8: While `pd_n` is 0, every clock output is low and `ser_hold` is 1. After `pd_n` returns to 1, the outputs resume at their periods and `ser_hold` returns to 0.
- R9: A cleared enable bit holds its own output low and leaves its neighbours running. Under any toggling of the enable bits, every high pulse lasts exactly floor(period/2) cycles and every low gap lasts at least period minus floor(period/2) cycles.
- R10: After a mode change, every PCI rising edge coincides with a rising edge of the host group and of the 66 MHz group.
- R11: While `rst_n` is 0, all clock outputs, `cpu_oe`, `sdram_oe`, `pci_oe` and `ref_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast model clock standing in for the PLL output |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 2 | Mode select: 00 tri-state, 01 test, 10 66 MHz host, 11 100 MHz host |
| pd_n | input | 1 | Active-low power-down |
| strap | input | 1 | IOAPIC rate strap, captured once after reset |
| en_cpu | input | N_CPU | Per-output enables, host group |
| en_sdram | input | N_SDRAM | Per-output enables, memory group |
| en_pci | input | N_PCI | Per-output enables, PCI group |
| en_usb | input | N_USB | Per-output enables, USB group |
| cpu_clk | output | N_CPU | Host clock outputs |
| sdram_clk | output | N_SDRAM | Memory clock outputs |
| m66_clk | output | N_M66 | Fixed 66 MHz outputs |
| pci_clk | output | N_PCI | PCI clock outputs |
| apic_clk | output | N_APIC | IOAPIC clock outputs |
| usb_clk | output | N_USB | 48 MHz clock outputs |
| ref_clk | output | 1 | Reference clock output |
| cpu_oe | output | 1 | Host group driver enable |
| sdram_oe | output | 1 | Memory group driver enable |
| pci_oe | output | 1 | PCI group driver enable |
| ref_oe | output | 1 | Shared strap/reference pin driver enable |
| ser_hold | output | 1 | Freezes the serial register block during power-down |

## Verification
The bench builds the block with two outputs in most groups and one in the 66 MHz and USB groups. It sets USB_PER to 4 and REF_PER to 5, so that an odd reference period with unequal high and low times is exercised. With these values every output pin can be measured in every mode and for both strap values, within a few thousand cycles. The small enable vectors also allow a dense enable-toggling pattern on a 6-cycle PCI output, which exposes any gating that cuts a pulse short.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    MODE_TRI  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_H66  = 2'b10,
    MODE_H100 = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    GRP_CPU   = 3'd0,
    GRP_SDRAM = 3'd1,
    GRP_M66   = 3'd2,
    GRP_PCI   = 3'd3,
    GRP_APIC  = 3'd4,
    GRP_USB   = 3'd5,
    GRP_REF   = 3'd6
  } grp_e;

  localparam int NUM_GRP = 7;

  // Period of a group in fast-clock cycles. Test mode treats the test clock as two fast cycles.
  function automatic int period_of(grp_e g, mode_e m, logic strap_hi, int usb_p, int ref_p);
    int p;
    p = 2;
    if (m == MODE_TEST) begin
      case (g)
        GRP_CPU, GRP_SDRAM, GRP_USB: p = 4;
        GRP_M66:                     p = 6;
        GRP_PCI, GRP_APIC:           p = 12;
        default:                     p = 2;
      endcase
    end else begin
      case (g)
        GRP_CPU:   p = (m == MODE_H66) ? 3 : 2;
        GRP_SDRAM: p = 2;
        GRP_M66:   p = 3;
        GRP_PCI:   p = 6;
        GRP_APIC:  p = strap_hi ? 6 : 12;
        GRP_USB:   p = usb_p;
        default:   p = ref_p;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int USB_PER = 4,
  parameter int REF_PER = 14,
  parameter int CNT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               sel_in,
  input  logic                     pd_n_in,
  input  logic                     strap_in,
  output logic                     clr,
  output logic                     run,
  output logic                     ser_hold,
  output logic                     cpu_oe,
  output logic                     sdram_oe,
  output logic                     pci_oe,
  output logic                     ref_oe,
  output logic [NUM_GRP*CNT_W-1:0] per_flat
);

  logic [1:0] sel_m_q, sel_s_q;
  logic       pd_m_q, pd_s_q;
  mode_e      mode_q, mode_d;
  logic       strap_q, strap_d;
  logic       done_q;
  logic       oe_q, oe_d;

  // next state
  always_comb begin
    mode_d  = mode_e'(sel_s_q);
    oe_d    = (mode_d != MODE_TRI);
    strap_d = done_q ? strap_q : strap_in;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_m_q <= 2'b00;
      sel_s_q <= 2'b00;
      pd_m_q  <= 1'b0;
      pd_s_q  <= 1'b0;
      mode_q  <= MODE_TRI;
      strap_q <= 1'b0;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sel_m_q <= sel_in;
      sel_s_q <= sel_m_q;
      pd_m_q  <= pd_n_in;
      pd_s_q  <= pd_m_q;
      mode_q  <= mode_d;
      strap_q <= strap_d;
      done_q  <= 1'b1;
      oe_q    <= oe_d;
    end
  end

  // realign on any mode change and on the strap capture cycle
  assign clr      = (mode_d != mode_q) || !done_q;
  assign run      = pd_s_q;
  assign ser_hold = !pd_s_q;
  assign cpu_oe   = oe_q;
  assign sdram_oe = oe_q;
  assign pci_oe   = oe_q;
  assign ref_oe   = done_q;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      per_flat[g*CNT_W +: CNT_W] = CNT_W'(period_of(grp_e'(3'(g)), mode_q, strap_q, USB_PER, REF_PER));
    end
  end

  // R6: once captured, the strap value never moves
  assert_strap_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(strap_q));

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic             lvl,
  output logic             phase0
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q >= period - 1'b1);
    if (clr || wrap) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lvl    = (cnt_q < (period >> 1));
  assign phase0 = (cnt_q == '0);

endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic en_req,
  output logic q
);

  logic en_eff_q, en_eff_d;
  logic q_q, q_d;

  // the enable is only taken over while the divided level is low
  always_comb begin
    en_eff_d = lvl ? en_eff_q : en_req;
    q_d      = lvl & en_eff_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_eff_q <= 1'b0;
      q_q      <= 1'b0;
    end else begin
      en_eff_q <= en_eff_d;
      q_q      <= q_d;
    end
  end

  assign q = q_q;

  // R9: an enable change lands only in a cycle where the pin is low
  assert_no_runt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_eff_q) |-> !q_q);

endmodule

// File: rtl/clkgen_bank.sv
module clkgen_bank #(
  parameter int N     = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  input  logic [N-1:0]     en,
  input  logic             run,
  output logic [N-1:0]     q,
  output logic             phase0
);

  logic lvl;

  clkgen_div #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .period (period),
    .lvl    (lvl),
    .phase0 (phase0)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    clkgen_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl),
      .en_req (en[i] & run),
      .q      (q[i])
    );
  end

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int N_CPU   = 3,
  parameter int N_SDRAM = 9,
  parameter int N_M66   = 2,
  parameter int N_PCI   = 8,
  parameter int N_APIC  = 2,
  parameter int N_USB   = 2,
  parameter int USB_PER = 4,
  parameter int REF_PER = 14
) (
  input  logic               clk_fast,
  input  logic               rst_n,
  input  logic [1:0]         sel,
  input  logic               pd_n,
  input  logic               strap,
  input  logic [N_CPU-1:0]   en_cpu,
  input  logic [N_SDRAM-1:0] en_sdram,
  input  logic [N_PCI-1:0]   en_pci,
  input  logic [N_USB-1:0]   en_usb,
  output logic [N_CPU-1:0]   cpu_clk,
  output logic [N_SDRAM-1:0] sdram_clk,
  output logic [N_M66-1:0]   m66_clk,
  output logic [N_PCI-1:0]   pci_clk,
  output logic [N_APIC-1:0]  apic_clk,
  output logic [N_USB-1:0]   usb_clk,
  output logic               ref_clk,
  output logic               cpu_oe,
  output logic               sdram_oe,
  output logic               pci_oe,
  output logic               ref_oe,
  output logic               ser_hold
);

  localparam int MAX_UR = (REF_PER > USB_PER) ? REF_PER : USB_PER;
  localparam int MAX_P  = (MAX_UR > 12) ? MAX_UR : 12;
  localparam int CNT_W  = $clog2(MAX_P + 1);

  logic rst_m_q, rst_i;
  logic clr, run;
  logic [NUM_GRP*CNT_W-1:0] per_flat;
  logic [NUM_GRP-1:0]       ph;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i   <= rst_m_q;
    end
  end

  clkgen_ctrl #(.USB_PER(USB_PER), .REF_PER(REF_PER), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk_fast),
    .rst_n    (rst_i),
    .sel_in   (sel),
    .pd_n_in  (pd_n),
    .strap_in (strap),
    .clr      (clr),
    .run      (run),
    .ser_hold (ser_hold),
    .cpu_oe   (cpu_oe),
    .sdram_oe (sdram_oe),
    .pci_oe   (pci_oe),
    .ref_oe   (ref_oe),
    .per_flat (per_flat)
  );

  clkgen_bank #(.N(N_CPU), .CNT_W(CNT_W)) u_cpu (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_CPU)*CNT_W +: CNT_W]),
    .en(en_cpu), .run(run), .q(cpu_clk), .phase0(ph[GRP_CPU]));

  clkgen_bank #(.N(N_SDRAM), .CNT_W(CNT_W)) u_sdram (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_SDRAM)*CNT_W +: CNT_W]),
    .en(en_sdram), .run(run), .q(sdram_clk), .phase0(ph[GRP_SDRAM]));

  clkgen_bank #(.N(N_M66), .CNT_W(CNT_W)) u_m66 (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_M66)*CNT_W +: CNT_W]),
    .en({N_M66{1'b1}}), .run(run), .q(m66_clk), .phase0(ph[GRP_M66]));

  clkgen_bank #(.N(N_PCI), .CNT_W(CNT_W)) u_pci (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_PCI)*CNT_W +: CNT_W]),
    .en(en_pci), .run(run), .q(pci_clk), .phase0(ph[GRP_PCI]));

  clkgen_bank #(.N(N_APIC), .CNT_W(CNT_W)) u_apic (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_APIC)*CNT_W +: CNT_W]),
    .en({N_APIC{1'b1}}), .run(run), .q(apic_clk), .phase0(ph[GRP_APIC]));

  clkgen_bank #(.N(N_USB), .CNT_W(CNT_W)) u_usb (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_USB)*CNT_W +: CNT_W]),
    .en(en_usb), .run(run), .q(usb_clk), .phase0(ph[GRP_USB]));

  clkgen_bank #(.N(1), .CNT_W(CNT_W)) u_ref (
    .clk(clk_fast), .rst_n(rst_i), .clr(clr),
    .period(per_flat[int'(GRP_REF)*CNT_W +: CNT_W]),
    .en(1'b1), .run(run), .q(ref_clk), .phase0(ph[GRP_REF]));

  // R7: an IOAPIC period start is always a PCI period start
  assert_apic_sync_R7: assert property (@(posedge clk_fast) disable iff (!rst_i)
    ph[GRP_APIC] |-> ph[GRP_PCI]);

  // R10: PCI period starts line up with host and 66 MHz period starts
  assert_edge_align_R10: assert property (@(posedge clk_fast) disable iff (!rst_i)
    ph[GRP_PCI] |-> (ph[GRP_CPU] && ph[GRP_M66]));

  // R10: a realign request restarts every divider together
  assert_realign_R10: assert property (@(posedge clk_fast) disable iff (!rst_i)
    clr |=> (&ph));

endmodule

// File: tb/sim_clkgen_top.sv
module sim_clkgen_top;

  localparam int NC = 2, NS = 2, NM = 1, NP = 2, NI = 2, NU = 1;
  localparam int UP = 4, RP = 5;
  localparam int OC = 0, OS = OC + NC, OM = OS + NS, OP = OM + NM;
  localparam int OI = OP + NP, OU = OI + NI, OR = OU + NU, NOBS = OR + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [1:0]    sel = 2'b11;
  logic          pd_n = 1'b1;
  logic          strap = 1'b1;
  logic [NC-1:0] en_cpu = '1;
  logic [NS-1:0] en_sdram = '1;
  logic [NP-1:0] en_pci = '1;
  logic [NU-1:0] en_usb = '1;
  logic [NC-1:0] cpu_clk;
  logic [NS-1:0] sdram_clk;
  logic [NM-1:0] m66_clk;
  logic [NP-1:0] pci_clk;
  logic [NI-1:0] apic_clk;
  logic [NU-1:0] usb_clk;
  logic          ref_clk, cpu_oe, sdram_oe, pci_oe, ref_oe, ser_hold;

  wire [NOBS-1:0] obs = {ref_clk, usb_clk, apic_clk, pci_clk, m66_clk, sdram_clk, cpu_clk};

  clkgen_top #(.N_CPU(NC), .N_SDRAM(NS), .N_M66(NM), .N_PCI(NP), .N_APIC(NI),
               .N_USB(NU), .USB_PER(UP), .REF_PER(RP)) u0 (
    .clk_fast(clk), .rst_n(rst_n), .sel(sel), .pd_n(pd_n), .strap(strap),
    .en_cpu(en_cpu), .en_sdram(en_sdram), .en_pci(en_pci), .en_usb(en_usb),
    .cpu_clk(cpu_clk), .sdram_clk(sdram_clk), .m66_clk(m66_clk), .pci_clk(pci_clk),
    .apic_clk(apic_clk), .usb_clk(usb_clk), .ref_clk(ref_clk), .cpu_oe(cpu_oe),
    .sdram_oe(sdram_oe), .pci_oe(pci_oe), .ref_oe(ref_oe), .ser_hold(ser_hold));

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int grp_of(int i);
    if (i < OS) return 0;
    if (i < OM) return 1;
    if (i < OP) return 2;
    if (i < OI) return 3;
    if (i < OU) return 4;
    if (i < OR) return 5;
    return 6;
  endfunction

  function automatic int exp_per(int g, int m, bit s);
    if (m == 1) begin
      case (g)
        0, 1, 5: return 4;
        2:       return 6;
        3, 4:    return 12;
        default: return 2;
      endcase
    end
    case (g)
      0:       return (m == 2) ? 3 : 2;
      1:       return 2;
      2:       return 3;
      3:       return 6;
      4:       return s ? 6 : 12;
      5:       return UP;
      default: return RP;
    endcase
  endfunction

  function automatic string tag_of(int g, int m);
    if (g == 4) return "R6";
    if (m == 1) return "R4";
    if (g == 2 || g == 5 || g == 6) return "R5";
    if (m == 2) return "R1";
    if (m == 3) return "R2";
    return "R3";
  endfunction

  // high time and period of one pin, counted in negedge samples
  task automatic meas(int idx, output int hi, output int per);
    int k;
    hi = -1;
    per = -1;
    k = 0;
    while (obs[idx] !== 1'b0 && k < 100) begin @(negedge clk); k++; end
    k = 0;
    while (obs[idx] !== 1'b1 && k < 100) begin @(negedge clk); k++; end
    if (k >= 100) return;
    hi = 0;
    while (obs[idx] === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
    per = hi;
    while (obs[idx] === 1'b0 && per < 200) begin @(negedge clk); per++; end
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    sel = 2'b11;
    pd_n = 1'b1;
    en_cpu = '1; en_sdram = '1; en_pci = '1; en_usb = '1;
    cyc(5);
    chk(obs == '0, "R11 outputs in reset", int'(obs), 0);
    chk({cpu_oe, sdram_oe, pci_oe, ref_oe} == 4'b0, "R11 enables in reset",
        int'({cpu_oe, sdram_oe, pci_oe, ref_oe}), 0);
    rst_n = 1'b1;
    cyc(8);
    chk(ref_oe == 1'b1, "R6 ref_oe after capture", int'(ref_oe), 1);
    strap = ~s;
  endtask

  initial begin
    int hi, per, e, g;
    bit pp, pc, pm, pa;
    for (int sv = 1; sv >= 0; sv--) begin
      do_reset(sv[0]);
      for (int m = 0; m < 4; m++) begin
        sel = m[1:0];
        cyc(12);
        chk(cpu_oe == (m != 0) && sdram_oe == (m != 0) && pci_oe == (m != 0),
            (m == 0) ? "R3 oe" : (m == 1) ? "R4 oe" : (m == 2) ? "R1 oe" : "R2 oe",
            int'({cpu_oe, sdram_oe, pci_oe}), (m != 0) ? 7 : 0);
        for (int i = 0; i < NOBS; i++) begin
          g = grp_of(i);
          e = exp_per(g, m, sv[0]);
          meas(i, hi, per);
          chk(per == e, tag_of(g, m), per, e);
          chk(hi == e / 2, tag_of(g, m), hi, e / 2);
        end
        // edge alignment
        pp = pci_clk[0]; pc = cpu_clk[0]; pm = m66_clk[0]; pa = apic_clk[0];
        for (int k = 0; k < 48; k++) begin
          @(negedge clk);
          if (pci_clk[0] && !pp)
            chk(cpu_clk[0] && !pc && m66_clk[0] && !pm, "R10 aligned rise",
                int'({cpu_clk[0], m66_clk[0]}), 3);
          if (apic_clk[0] && !pa)
            chk(pci_clk[0] && !pp, "R7 apic on pci rise", int'(pci_clk[0]), 1);
          pp = pci_clk[0]; pc = cpu_clk[0]; pm = m66_clk[0]; pa = apic_clk[0];
        end
      end
    end

    // R9: single enable cleared
    sel = 2'b10;
    cyc(12);
    en_cpu = 2'b01;
    cyc(12);
    begin
      int ones, tog;
      bit prv;
      ones = 0; tog = 0; prv = cpu_clk[0];
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (cpu_clk[1]) ones++;
        if (cpu_clk[0] != prv) tog++;
        prv = cpu_clk[0];
      end
      chk(ones == 0, "R9 disabled pin low", ones, 0);
      chk(tog > 10, "R9 neighbour runs", tog, 26);
    end
    en_cpu = '1;

    // R9: toggled enable never yields a short pulse
    begin
      int run_len, bad_hi, bad_lo;
      bit prv, seen;
      run_len = 0; bad_hi = 0; bad_lo = 0; seen = 1'b0;
      prv = pci_clk[0];
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (pci_clk[0] == prv) run_len++;
        else begin
          if (seen && prv && run_len != 3) bad_hi++;
          if (seen && !prv && run_len < 3) bad_lo++;
          seen = 1'b1;
          run_len = 1;
        end
        prv = pci_clk[0];
        en_pci[0] = (((k * 7) % 5) < 2) ^ (k[4]);
      end
      chk(bad_hi == 0, "R9 high pulse width", bad_hi, 0);
      chk(bad_lo == 0, "R9 low gap width", bad_lo, 0);
    end
    en_pci = '1;

    // R8: power-down stops low
    pd_n = 1'b0;
    cyc(20);
    begin
      int viol;
      viol = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (obs != '0 || !ser_hold) viol++;
      end
      chk(viol == 0, "R8 stopped low", viol, 0);
    end
    pd_n = 1'b1;
    cyc(20);
    chk(ser_hold == 1'b0, "R8 hold released", int'(ser_hold), 0);
    meas(OP, hi, per);
    chk(per == 6, "R8 resume period", per, 6);
    meas(OI, hi, per);
    chk(per == 12, "R6 strap change ignored", per, 12);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule